// File: doc/BRIEF.md
# Mode-Split Direct-Mapped Translation Buffer

This block keeps recently used logical-to-physical page translations so that most accesses avoid a table walk. The storage is direct mapped and split by privilege: the mode bit of a lookup forms the top bit of the entry index, so user and supervisor translations live in two equal halves and never evict each other. With the default parameters the array holds 2048 entries, 1024 per mode, and each entry stores a tag (the upper logical page bits), a physical page and a valid bit.

A requester presents a logical page and mode while `lk_rdy` is high. One cycle later a response reports hit with the physical page, or miss. A miss moves the controller from state IDLE to state WALK through transition MISS_START. In WALK it holds a walk request towards the table walker. The walker's completion strobe writes the returned page into the entry and takes the controller back to IDLE through transition WALK_FILL. The requester then repeats the lookup. Invalidation comes in three forms: a selective purge of one slot, a complete purge, and a complete purge raised automatically by a root pointer write strobe. Every purge takes effect in the cycle it is presented, in either state.

Top module: `xlt_tlb`

## Requirements
- R1: After reset `lk_rdy` is 1, `res_vld` and `walk_req` are 0, and every entry is invalid, so the first lookup of any page misses.
- R2: The entry index is {mode, lpn[SET_W-1:0]} and the tag is lpn[LPN_W-1:SET_W]. A fill overwrites whatever its slot held, so a page whose tag differs from the stored one misses.
- R3: A lookup is accepted when `lk_req` and `lk_rdy` are both 1. Exactly one cycle later `res_vld` is 1 for one cycle, with `res_hit`, and with `res_ppn` equal to the stored page on a hit and 0 on a miss.
- R4: User (mode 0) and supervisor (mode 1) entries for the same logical page are independent and may hold different physical pages.
- R5: On a miss, `lk_rdy` is 0 from the next cycle and `walk_req` stays 1, with `walk_lpn` and `walk_sup` equal to the missed page, until `walk_done`. The cycle after `walk_done`, `lk_rdy` is 1 again and a new lookup of that page hits with the `walk_ppn` given at completion.
- R6: A lookup request presented while `lk_rdy` is 0 is ignored: it produces no response and does not alter the pending walk.
- R7: A selective purge (`pg_one`) invalidates the slot selected by `pg_lpn` and `pg_sup`, whatever tag the slot holds. All other slots are kept.
- R8: A complete purge (`pg_all`) invalidates every entry in a single cycle.
- R9: A root pointer write strobe (`root_wr`) purges every entry exactly as `pg_all` does.
- R10: A lookup in the same cycle as a purge that covers its slot reports a miss and starts a walk. A selective purge of another slot does not affect the lookup.
- R11: When a fill and a purge covering the filled slot fall in the same cycle, the purge wins and the slot is invalid afterwards. A selective purge of a different slot leaves the fill in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_sup | input | 1 | Lookup mode: 1 supervisor, 0 user |
| lk_lpn | input | LPN_W | Logical page number to translate |
| lk_rdy | output | 1 | Controller is in IDLE and accepts a lookup |
| res_vld | output | 1 | Lookup response strobe |
| res_hit | output | 1 | Response is a hit |
| res_ppn | output | PPN_W | Physical page on a hit, 0 on a miss |
| walk_req | output | 1 | Table walk requested (state WALK) |
| walk_sup | output | 1 | Mode of the page to walk |
| walk_lpn | output | LPN_W | Logical page to walk |
| walk_done | input | 1 | Walk complete; `walk_ppn` is valid |
| walk_ppn | input | PPN_W | Physical page returned by the walker |
| pg_one | input | 1 | Selective purge strobe |
| pg_sup | input | 1 | Mode of the slot to purge |
| pg_lpn | input | LPN_W | Logical page of the slot to purge |
| pg_all | input | 1 | Complete purge strobe |
| root_wr | input | 1 | Root pointer write strobe, purges all entries |

## Verification
Two pairs of events can meet in one cycle. A purge can meet a lookup, and a purge can meet the fill that completes a walk. The bench provokes both by driving the purge strobes in exactly the cycle that carries `lk_req` or `walk_done`. It aims them at the same slot and at a different slot. The lookup case is judged from the response it gets. The fill case is judged from the hit or miss of the next lookup of the filled page. Both are compared against an array model kept in the bench, which applies the fill first and the purge after it.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } xlt_state_e;
endpackage

// File: rtl/xlt_store.sv
module xlt_store #(
    parameter int SET_W = 10,
    parameter int TAG_W = 10,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W:0]   rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PPN_W-1:0] rd_ppn,
    input  logic             wr_en,
    input  logic [SET_W:0]   wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             clr_all,
    input  logic             clr_one,
    input  logic [SET_W:0]   clr_idx
);
    localparam int IDX_W = SET_W + 1;
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PPN_W-1:0] ppn_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            ppn_q[wr_idx] <= wr_ppn;
        end
    end

    // One valid flop per slot; clearing outranks setting.
    for (genvar e = 0; e < DEPTH; e++) begin : g_vld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[e] <= 1'b0;
            end else if (clr_all || (clr_one && clr_idx == IDX_W'(e))) begin
                vld_q[e] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                vld_q[e] <= 1'b1;
            end
        end
    end

    assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_ppn = ppn_q[rd_idx];
endmodule

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
    import xlt_pkg::*;
#(
    parameter int LPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic             lk_sup,
    input  logic [LPN_W-1:0] lk_lpn,
    input  logic             hit_eff,
    input  logic [PPN_W-1:0] hit_ppn,
    input  logic             walk_done,
    output logic             lk_rdy,
    output logic             res_vld,
    output logic             res_hit,
    output logic [PPN_W-1:0] res_ppn,
    output logic             walk_req,
    output logic             walk_sup,
    output logic [LPN_W-1:0] walk_lpn,
    output logic             fill_en
);
    xlt_state_e state_q, state_d;
    logic       accept;

    assign accept = lk_req && (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !hit_eff) state_d = ST_WALK; // MISS_START
            ST_WALK: if (walk_done)          state_d = ST_IDLE; // WALK_FILL
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_hit  <= 1'b0;
            res_ppn  <= '0;
            walk_sup <= 1'b0;
            walk_lpn <= '0;
        end else begin
            res_vld <= accept;
            res_hit <= accept && hit_eff;
            res_ppn <= (accept && hit_eff) ? hit_ppn : '0;
            if (accept) begin
                walk_sup <= lk_sup;
                walk_lpn <= lk_lpn;
            end
        end
    end

    assign lk_rdy   = (state_q == ST_IDLE);
    assign walk_req = (state_q == ST_WALK);
    assign fill_en  = walk_req && walk_done;
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb #(
    parameter int LPN_W = 20,
    parameter int SET_W = 10,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic             lk_sup,
    input  logic [LPN_W-1:0] lk_lpn,
    output logic             lk_rdy,
    output logic             res_vld,
    output logic             res_hit,
    output logic [PPN_W-1:0] res_ppn,
    output logic             walk_req,
    output logic             walk_sup,
    output logic [LPN_W-1:0] walk_lpn,
    input  logic             walk_done,
    input  logic [PPN_W-1:0] walk_ppn,
    input  logic             pg_one,
    input  logic             pg_sup,
    input  logic [LPN_W-1:0] pg_lpn,
    input  logic             pg_all,
    input  logic             root_wr
);
    localparam int TAG_W = LPN_W - SET_W;

    logic [SET_W:0]   lk_idx, wk_idx, pg_idx;
    logic [TAG_W-1:0] lk_tag, wk_tag;
    logic             rd_hit, hit_eff, fill_en, clr_all, kill;
    logic [PPN_W-1:0] rd_ppn;

    assign lk_idx  = {lk_sup, lk_lpn[SET_W-1:0]};
    assign lk_tag  = lk_lpn[LPN_W-1:SET_W];
    assign wk_idx  = {walk_sup, walk_lpn[SET_W-1:0]};
    assign wk_tag  = walk_lpn[LPN_W-1:SET_W];
    assign pg_idx  = {pg_sup, pg_lpn[SET_W-1:0]};

    assign clr_all = pg_all || root_wr;
    assign kill    = clr_all || (pg_one && pg_idx == lk_idx);
    assign hit_eff = rd_hit && !kill;

    xlt_store #(.SET_W(SET_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_hit(rd_hit), .rd_ppn(rd_ppn),
        .wr_en(fill_en), .wr_idx(wk_idx), .wr_tag(wk_tag), .wr_ppn(walk_ppn),
        .clr_all(clr_all), .clr_one(pg_one), .clr_idx(pg_idx)
    );

    xlt_ctrl #(.LPN_W(LPN_W), .PPN_W(PPN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_sup(lk_sup), .lk_lpn(lk_lpn),
        .hit_eff(hit_eff), .hit_ppn(rd_ppn), .walk_done(walk_done),
        .lk_rdy(lk_rdy), .res_vld(res_vld), .res_hit(res_hit), .res_ppn(res_ppn),
        .walk_req(walk_req), .walk_sup(walk_sup), .walk_lpn(walk_lpn),
        .fill_en(fill_en)
    );
endmodule

// File: rtl/xlt_tlb_chk.sv
module xlt_tlb_chk #(
    parameter int LPN_W = 20,
    parameter int PPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic             lk_rdy,
    input logic             res_vld,
    input logic             res_hit,
    input logic [PPN_W-1:0] res_ppn,
    input logic             walk_req,
    input logic [LPN_W-1:0] walk_lpn,
    input logic             walk_sup,
    input logic             walk_done,
    input logic             pg_all,
    input logic             root_wr
);
    assert_resp_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(lk_req && lk_rdy));

    assert_miss_zero_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_ppn == '0));

    assert_miss_starts_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> walk_req);

    assert_walk_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_done) |=> (walk_req && $stable(walk_lpn) && $stable(walk_sup)));

    assert_walk_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && walk_done) |=> lk_rdy);

    assert_busy_no_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_rdy |=> !res_vld);

    assert_purge_lookup_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_rdy && (pg_all || root_wr)) |=> (res_vld && !res_hit));
endmodule

bind xlt_tlb xlt_tlb_chk #(.LPN_W(LPN_W), .PPN_W(PPN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_rdy(lk_rdy),
    .res_vld(res_vld), .res_hit(res_hit), .res_ppn(res_ppn),
    .walk_req(walk_req), .walk_lpn(walk_lpn), .walk_sup(walk_sup),
    .walk_done(walk_done), .pg_all(pg_all), .root_wr(root_wr)
);

// File: tb/sim_xlt_tlb.sv
module sim_xlt_tlb;
    localparam int LW = 6;
    localparam int SW = 3;
    localparam int PW = 8;
    localparam int NSLOT = 2 << SW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 1'b0, lk_sup = 1'b0;
    logic [LW-1:0] lk_lpn = '0;
    logic lk_rdy, res_vld, res_hit, walk_req, walk_sup;
    logic [PW-1:0] res_ppn;
    logic [LW-1:0] walk_lpn;
    logic walk_done = 1'b0;
    logic [PW-1:0] walk_ppn = '0;
    logic pg_one = 1'b0, pg_sup = 1'b0, pg_all = 1'b0, root_wr = 1'b0;
    logic [LW-1:0] pg_lpn = '0;

    int checks = 0;
    int fails = 0;
    int gen = 0;
    bit mvld [NSLOT];
    int mtag [NSLOT];
    int mppn [NSLOT];

    always #2 clk = ~clk;

    xlt_tlb #(.LPN_W(LW), .SET_W(SW), .PPN_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_sup(lk_sup), .lk_lpn(lk_lpn),
        .lk_rdy(lk_rdy), .res_vld(res_vld), .res_hit(res_hit), .res_ppn(res_ppn),
        .walk_req(walk_req), .walk_sup(walk_sup), .walk_lpn(walk_lpn),
        .walk_done(walk_done), .walk_ppn(walk_ppn),
        .pg_one(pg_one), .pg_sup(pg_sup), .pg_lpn(pg_lpn),
        .pg_all(pg_all), .root_wr(root_wr)
    );

    function automatic int slot(input int lpn, input int sup);
        return sup * (1 << SW) + (lpn % (1 << SW));
    endfunction

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic model_purge(input bit all, input bit one, input int plpn, input int psup);
        if (all) for (int k = 0; k < NSLOT; k++) mvld[k] = 1'b0;
        if (one) mvld[slot(plpn, psup)] = 1'b0;
    endtask

    task automatic pulse(input bit all, input bit one, input int plpn, input int psup, input bit rw);
        @(negedge clk);
        pg_all = all; pg_one = one; pg_lpn = LW'(plpn); pg_sup = psup[0]; root_wr = rw;
        @(negedge clk);
        pg_all = 1'b0; pg_one = 1'b0; root_wr = 1'b0;
        model_purge(all || rw, one, plpn, psup);
    endtask

    task automatic look(input int lpn, input int sup, input string rq,
                        input bit la = 0, input bit lo = 0, input int lpl = 0, input int lps = 0,
                        input bit fa = 0, input bit fo = 0, input int fpl = 0, input int fps = 0);
        int  i;
        bit  exh;
        int  exp_ppn;
        int  np;
        i = slot(lpn, sup);
        exh = mvld[i] && (mtag[i] == (lpn >> SW));
        if (la) exh = 1'b0;
        if (lo && slot(lpl, lps) == i) exh = 1'b0;
        exp_ppn = exh ? mppn[i] : 0;
        @(negedge clk);
        lk_req = 1'b1; lk_lpn = LW'(lpn); lk_sup = sup[0];
        pg_all = la; pg_one = lo; pg_lpn = LW'(lpl); pg_sup = lps[0];
        @(negedge clk);
        lk_req = 1'b0; pg_all = 1'b0; pg_one = 1'b0;
        model_purge(la, lo, lpl, lps);
        chk(rq, "res_vld", longint'(res_vld), 1);
        chk(rq, "res_hit", longint'(res_hit), longint'(exh));
        chk(rq, "res_ppn", longint'(res_ppn), longint'(exp_ppn));
        if (!exh) begin
            chk(rq, "walk_req", longint'(walk_req), 1);
            chk(rq, "walk_lpn", longint'(walk_lpn), longint'(lpn));
            chk(rq, "walk_sup", longint'(walk_sup), longint'(sup));
            chk(rq, "lk_rdy busy", longint'(lk_rdy), 0);
            gen++;
            np = (lpn * 7 + sup * 131 + gen * 29) % 256;
            walk_done = 1'b1; walk_ppn = PW'(np);
            pg_all = fa; pg_one = fo; pg_lpn = LW'(fpl); pg_sup = fps[0];
            @(negedge clk);
            walk_done = 1'b0; pg_all = 1'b0; pg_one = 1'b0;
            mvld[i] = 1'b1; mtag[i] = lpn >> SW; mppn[i] = np;
            model_purge(fa, fo, fpl, fps);
            chk(rq, "lk_rdy after fill", longint'(lk_rdy), 1);
            chk(rq, "walk_req after fill", longint'(walk_req), 0);
        end else begin
            chk(rq, "lk_rdy on hit", longint'(lk_rdy), 1);
        end
    endtask

    initial begin
        for (int k = 0; k < NSLOT; k++) begin mvld[k] = 1'b0; mtag[k] = 0; mppn[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "lk_rdy", longint'(lk_rdy), 1);
        chk("R1", "res_vld", longint'(res_vld), 0);
        chk("R1", "walk_req", longint'(walk_req), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R5: every page twice per mode; tag conflicts evict.
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < (1 << LW); p++) begin
                look(p, s, "R1 R2 R5");
                look(p, s, "R3 R5");
            end

        // R4: both halves hold the same pages with their own physical pages.
        for (int p = 56; p < 64; p++) begin
            look(p, 0, "R4");
            look(p, 1, "R4");
            chk("R4", "mode pages differ", longint'(mppn[slot(p, 0)] != mppn[slot(p, 1)]), 1);
        end

        // R6: lookup while walking is ignored.
        @(negedge clk);
        lk_req = 1'b1; lk_lpn = LW'(0); lk_sup = 1'b0;
        @(negedge clk);
        lk_lpn = LW'(57);
        chk("R6", "first res_hit", longint'(res_hit), 0);
        @(negedge clk);
        lk_req = 1'b0;
        chk("R6", "ignored res_vld", longint'(res_vld), 0);
        chk("R6", "walk_lpn kept", longint'(walk_lpn), 0);
        chk("R6", "walk_req kept", longint'(walk_req), 1);
        walk_done = 1'b1; walk_ppn = PW'(8'hA5);
        @(negedge clk);
        walk_done = 1'b0;
        mvld[slot(0, 0)] = 1'b1; mtag[slot(0, 0)] = 0; mppn[slot(0, 0)] = 8'hA5;
        look(0, 0, "R5 R6");
        look(57, 0, "R6");

        // R7: selective purge, including a slot whose tag differs.
        pulse(0, 1, 60, 0, 0);
        look(60, 1, "R7 other mode kept");
        look(60, 0, "R7 purged");
        pulse(0, 1, 4, 1, 0);
        look(60, 1, "R7 tag ignored");
        look(61, 1, "R7 neighbour kept");

        // R8, R9: complete purges.
        pulse(1, 0, 0, 0, 0);
        for (int s = 0; s < 2; s++) for (int p = 0; p < 8; p++) look(p + 8, s, "R8");
        pulse(0, 0, 0, 0, 1);
        for (int s = 0; s < 2; s++) for (int p = 0; p < 8; p++) look(p + 8, s, "R9");

        // R10: purge in the lookup cycle.
        look(9, 0, "R10 warm");
        look(9, 0, "R10 all", 1);
        look(9, 0, "R10 after");
        look(10, 1, "R10 one same", 0, 1, 10, 1);
        look(11, 1, "R10 warm2");
        look(11, 1, "R10 one other", 0, 1, 12, 1);

        // R11: purge in the fill cycle.
        look(40, 0, "R11 all", 0, 0, 0, 0, 1);
        look(40, 0, "R11 after all");
        look(41, 1, "R11 one same", 0, 0, 0, 0, 0, 1, 9, 1);
        look(41, 1, "R11 after one");
        look(42, 1, "R11 one other", 0, 0, 0, 0, 0, 1, 43, 1);
        look(42, 1, "R11 kept");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule